// File: doc/BRIEF.md
# Programmable Reed-Solomon Parity Generator

This block computes the check symbols of a systematic Reed-Solomon code over GF(2^8). It takes one information symbol on each clock where the enable is high and divides the message by a generator polynomial in a linear feedback shift register. The remainder is then shifted out, one check symbol per clock, while the unload command is held.

The number of check symbols T can be changed at run time, from 0 to 20. The generator taps arrive on a wide input vector. One datapath serves every value of T. The field reduction polynomial is fixed by a parameter: 0x11D is the default and 0x187 is the alternative. With 0x11D the generator roots normally run from alpha^0 upward; with 0x187 they run from alpha^120 upward. The surrounding logic owns tap storage, block counting and the choice between passing data through and sending parity.

Top module: `rs_parity_lfsr`

## Requirements
- R1: The asynchronous reset `rst`, active high, clears every remainder stage. While it is held and after it is released, `par_out` is 0 until a symbol is absorbed.
- R2: Let `taps[8i+7:8i]` be the coefficient of x^i of the monic generator g(x) of degree T, where T is the value of `par_len`. After K symbols have been absorbed starting at a start pulse, `par_out` equals the x^(T-1) coefficient of m(x)·x^T mod g(x). Here m(x) carries the first symbol at the highest degree.
- R3: On each clock with `unload` high, the feedback is zero and each stage moves up by one. `par_out` therefore presents the check symbols in order from the highest degree down. After T unload clocks it reads 0.
- R4: A clock with `sym_en` and `unload` both low leaves the remainder, and so `par_out`, unchanged.
- R5: A `start` pulse together with `sym_en` discards the earlier remainder in the same clock that absorbs the first symbol. This holds even in the middle of an unload.
- R6: With `par_len` = 0, `par_out` stays 0 whatever the input.
- R7: Any T from 1 to 20 is served by the same stages. Taps at index T or above have no effect, and stages at or above T are held at zero.
- R8: The parameter `FIELD_POLY` selects the field reduction. Both 0x11D and 0x187 give correct parity with their own generators.
- R9: `unload` takes priority over `sym_en`. A symbol presented during an unload clock is not absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| sym_in | input | 8 | Information symbol |
| sym_en | input | 1 | Absorb `sym_in` this clock |
| start | input | 1 | First symbol of a new block; clears the remainder |
| unload | input | 1 | Shift the remainder out with the feedback gated to zero |
| taps | input | 160 | Generator coefficients; byte i is the coefficient of x^i |
| par_len | input | 5 | Active number of check symbols T, 0 to 20 |
| par_out | output | 8 | Current check symbol (the highest active stage) |

## Verification
The assertions assume that `par_len` never exceeds 20. Their checks on the next cycle hold only when `par_len` has not changed across that clock, so each property excuses cycles in which it did. The bench keeps `par_len` and `taps` fixed for the whole of each block and changes them only between blocks. The start-pulse property that compares against the input symbol fires only when tap 0 is 1, which is the case for a T = 1 generator rooted at alpha^0. The bench's T = 1 vectors on the default field meet that condition.

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr #(
  parameter int SYM_W = 8,
  parameter int MAX_PAR = 20,
  parameter int LEN_W = 5,
  parameter logic [SYM_W:0] FIELD_POLY = 9'h11D
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SYM_W-1:0]         sym_in,
  input  logic                     sym_en,
  input  logic                     start,
  input  logic                     unload,
  input  logic [MAX_PAR*SYM_W-1:0] taps,
  input  logic [LEN_W-1:0]         par_len,
  output logic [SYM_W-1:0]         par_out
);

  localparam logic [SYM_W-1:0] RED   = FIELD_POLY[SYM_W-1:0];
  localparam logic [LEN_W-1:0] T_CAP = LEN_W'(MAX_PAR);

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                              input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < SYM_W; k++) begin
      if (b[k]) acc ^= sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ RED) : (sh << 1);
    end
    return acc;
  endfunction

  logic [LEN_W-1:0]                t_act;
  logic [SYM_W-1:0]                top, fb;
  logic                            step;
  logic [SYM_W-1:0]                rem_q [MAX_PAR];
  logic [MAX_PAR-1:0][SYM_W-1:0]   nxt;

  assign t_act = (par_len > T_CAP) ? T_CAP : par_len;
  assign step  = sym_en | unload;

  always_comb begin
    top = '0;
    for (int i = 0; i < MAX_PAR; i++)
      if (LEN_W'(i + 1) == t_act) top = rem_q[i];
  end

  assign fb = unload ? '0 : (sym_in ^ (start ? '0 : top));

  for (genvar g = 0; g < MAX_PAR; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign nxt[g] = gf_mul(fb, taps[g*SYM_W +: SYM_W]);
    end else begin : g_rest
      assign nxt[g] = (start ? '0 : rem_q[g-1]) ^ gf_mul(fb, taps[g*SYM_W +: SYM_W]);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < MAX_PAR; i++) rem_q[i] <= '0;
    end else if (step) begin
      for (int i = 0; i < MAX_PAR; i++)
        rem_q[i] <= (LEN_W'(i) < t_act) ? nxt[i] : '0;
    end
  end

  assign par_out = top;

endmodule

module rs_parity_lfsr_chk #(
  parameter int SYM_W = 8,
  parameter int MAX_PAR = 20,
  parameter int LEN_W = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic [SYM_W-1:0]         sym_in,
  input logic                     sym_en,
  input logic                     start,
  input logic                     unload,
  input logic [MAX_PAR*SYM_W-1:0] taps,
  input logic [LEN_W-1:0]         par_len,
  input logic [SYM_W-1:0]         par_out
);

  assert_len_range_R7: assert property (@(posedge clk) disable iff (rst)
    par_len <= LEN_W'(MAX_PAR));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sym_en && !unload) |=> ($stable(par_out) || !$stable(par_len)));

  assert_unload_drain_R3: assert property (@(posedge clk) disable iff (rst)
    (unload && par_len == 1) |=> (par_out == '0 || !$stable(par_len)));

  assert_start_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (start && sym_en && !unload && sym_in == '0) |=> (par_out == '0 || !$stable(par_len)));

  assert_start_first_R5: assert property (@(posedge clk) disable iff (rst)
    (start && sym_en && !unload && par_len == 1 && taps[SYM_W-1:0] == SYM_W'(1))
      |=> (par_out == $past(sym_in) || !$stable(par_len)));

  assert_no_parity_R6: assert property (@(posedge clk) disable iff (rst)
    (par_len == '0) |-> (par_out == '0));

endmodule

bind rs_parity_lfsr rs_parity_lfsr_chk #(.SYM_W(SYM_W), .MAX_PAR(MAX_PAR), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .sym_in(sym_in), .sym_en(sym_en), .start(start),
  .unload(unload), .taps(taps), .par_len(par_len), .par_out(par_out));

// File: tb/rs_parity_lfsr_tb_top.sv
module rs_parity_lfsr_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   sym_in = '0;
  logic         sym_en = 1'b0, start = 1'b0, unload = 1'b0;
  logic [159:0] taps_a = '0, taps_b = '0;
  logic [4:0]   par_len = 5'd16;
  logic [7:0]   out_a, out_b;
  int           checks = 0, fails = 0;
  bit           done = 1'b0;
  logic [7:0]   msg [0:255];

  always #10 clk = ~clk;

  rs_parity_lfsr #(.FIELD_POLY(9'h11D)) dut_i (
    .clk(clk), .rst(rst), .sym_in(sym_in), .sym_en(sym_en), .start(start),
    .unload(unload), .taps(taps_a), .par_len(par_len), .par_out(out_a));

  rs_parity_lfsr #(.FIELD_POLY(9'h187)) dut_p187 (
    .clk(clk), .rst(rst), .sym_in(sym_in), .sym_en(sym_en), .start(start),
    .unload(unload), .taps(taps_b), .par_len(par_len), .par_out(out_b));

  // {T, K, base, step, flags}: flags bit0 = idle gap after each symbol, bit1 = junk symbols during unload
  localparam logic [39:0] VEC [8] = '{
    {8'd16, 8'd40, 8'h11, 8'h07, 8'h00},
    {8'd1,  8'd10, 8'h3C, 8'h05, 8'h00},
    {8'd2,  8'd5,  8'hF0, 8'h13, 8'h01},
    {8'd20, 8'd60, 8'h00, 8'h01, 8'h00},
    {8'd3,  8'd30, 8'h5A, 8'h0B, 8'h03},
    {8'd8,  8'd1,  8'hC3, 8'h00, 8'h00},
    {8'd0,  8'd12, 8'h77, 8'h09, 8'h00},
    {8'd11, 8'd25, 8'h81, 8'h1D, 8'h02}
  };

  function automatic logic [7:0] gfm(input logic [7:0] a, input logic [7:0] b, input logic [8:0] poly);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'(poly) << (i - 8);
    return p[7:0];
  endfunction

  // generator coefficients g[0..T], g[T] = 1, packed byte i at [8i+:8]
  function automatic logic [167:0] make_gen(input int t, input logic [8:0] poly, input int first);
    logic [7:0] g [0:20];
    logic [7:0] root;
    logic [167:0] r;
    for (int i = 0; i <= 20; i++) g[i] = '0;
    g[0] = 8'd1;
    root = 8'd1;
    for (int i = 0; i < first; i++) root = gfm(root, 8'd2, poly);
    for (int j = 0; j < t; j++) begin
      for (int i = t; i >= 1; i--) g[i] = g[i-1] ^ gfm(root, g[i], poly);
      g[0] = gfm(root, g[0], poly);
      root = gfm(root, 8'd2, poly);
    end
    r = '0;
    for (int i = 0; i <= 20; i++) r[8*i +: 8] = g[i];
    return r;
  endfunction

  function automatic logic [159:0] taps_of(input logic [167:0] g, input int t);
    logic [159:0] r;
    for (int i = 0; i < 20; i++) r[8*i +: 8] = (i < t) ? g[8*i +: 8] : (8'hA5 ^ 8'(i * 37));
    return r;
  endfunction

  // long division of msg(x)*x^T by g(x); check symbol j (highest degree first) at [8j+:8]
  function automatic logic [159:0] parity_of(input int k, input int t, input logic [167:0] g, input logic [8:0] poly);
    logic [7:0] bf [0:299];
    logic [7:0] c;
    logic [159:0] r;
    for (int i = 0; i < k; i++) bf[i] = msg[i];
    for (int i = 0; i < t; i++) bf[k+i] = '0;
    for (int i = 0; i < k; i++) begin
      c = bf[i];
      for (int j = 1; j <= t; j++) bf[i+j] ^= gfm(c, g[8*(t-j) +: 8], poly);
    end
    r = '0;
    for (int j = 0; j < t; j++) r[8*j +: 8] = bf[k+j];
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic feed(input int k, input bit gap);
    for (int s = 0; s < k; s++) begin
      sym_in = msg[s]; sym_en = 1'b1; start = (s == 0); unload = 1'b0;
      @(negedge clk);
      if (gap) begin
        sym_en = 1'b0; start = 1'b0; sym_in = 8'hEE;
        @(negedge clk);
      end
    end
    sym_en = 1'b0; start = 1'b0; sym_in = '0;
  endtask

  // Runs one block and checks every check symbol of both fields.
  task automatic run_block(input int t, input int k, input logic [7:0] base, input logic [7:0] stp,
                           input bit gap, input bit junk, input string tag);
    logic [167:0] ga, gb;
    logic [159:0] pa, pb;
    for (int s = 0; s < k; s++) msg[s] = (base ^ 8'(s * stp)) + 8'(s);
    ga = make_gen(t, 9'h11D, 0);
    gb = make_gen(t, 9'h187, 120);
    taps_a = taps_of(ga, t);
    taps_b = taps_of(gb, t);
    par_len = 5'(t);
    pa = parity_of(k, t, ga, 9'h11D);
    pb = parity_of(k, t, gb, 9'h187);
    feed(k, gap);
    if (t == 0) begin
      check({tag, " R6 T=0 field 11D"}, out_a, 8'h00);
      check({tag, " R6 T=0 field 187"}, out_b, 8'h00);
      return;
    end
    check({tag, " R2 first check symbol 11D"}, out_a, pa[7:0]);
    check({tag, " R8 first check symbol 187"}, out_b, pb[7:0]);
    for (int j = 1; j <= t; j++) begin
      unload = 1'b1;
      sym_en = junk; sym_in = junk ? 8'hFF : 8'h00;
      @(negedge clk);
      check({tag, junk ? " R9 R3 unload 11D" : " R3 unload 11D"}, out_a, (j < t) ? pa[8*j +: 8] : 8'h00);
      check({tag, junk ? " R9 R8 unload 187" : " R8 unload 187"}, out_b, (j < t) ? pb[8*j +: 8] : 8'h00);
    end
    unload = 1'b0; sym_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [167:0] g16;
    logic [159:0] p16;
    repeat (3) @(negedge clk);
    check("R1 reset state 11D", out_a, 8'h00);
    check("R1 reset state 187", out_b, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", out_a, 8'h00);

    foreach (VEC[v]) begin
      run_block(int'(VEC[v][39:32]), int'(VEC[v][31:24]), VEC[v][23:16], VEC[v][15:8],
                VEC[v][0], VEC[v][1], $sformatf("vec%0d R7", v));
    end

    // R4: idle clocks hold the remainder
    for (int s = 0; s < 20; s++) msg[s] = 8'(s * 29 + 3);
    g16 = make_gen(16, 9'h11D, 0);
    taps_a = taps_of(g16, 16);
    par_len = 5'd16;
    p16 = parity_of(20, 16, g16, 9'h11D);
    feed(20, 1'b0);
    repeat (4) @(negedge clk);
    check("R4 idle hold", out_a, p16[7:0]);
    unload = 1'b1; @(negedge clk); unload = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 idle hold during unload", out_a, p16[15:8]);

    // R5: restart in the middle of the information part
    for (int s = 0; s < 7; s++) begin
      sym_in = 8'(s + 100); sym_en = 1'b1; start = (s == 0);
      @(negedge clk);
    end
    sym_en = 1'b0; start = 1'b0;
    run_block(6, 15, 8'h42, 8'h0D, 1'b0, 1'b0, "R5 restart mid-data");

    // R5: restart in the middle of an unload
    for (int s = 0; s < 9; s++) msg[s] = 8'(s * 7 + 1);
    feed(9, 1'b0);
    unload = 1'b1; repeat (2) @(negedge clk); unload = 1'b0;
    run_block(6, 12, 8'h99, 8'h03, 1'b1, 1'b0, "R5 restart mid-unload");

    // R1: reset while a remainder is held
    for (int s = 0; s < 5; s++) msg[s] = 8'h5F;
    feed(5, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears held remainder 11D", out_a, 8'h00);
    check("R1 reset clears held remainder 187", out_b, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule